// File: doc/BRIEF.md
# Two-Wire Slave Interface with Alert Response

This block is the serial management front end of a multi-port controller. It listens to a shared two-wire bus (SMBus, I2C compatible) as a pure target, never drives the clock line, and pulls the data line low only to acknowledge or to send a bit of zero. It answers three addresses. The first is its own address, built from a fixed prefix and four select pins. The second is a common address that all instances share, so that one write can configure many devices. The third is the SMBus alert response address, which it answers only while its own interrupt is asserted.

Behind the bus engine sits a small register file. It holds event pending flags, an event enable mask, per-port detect and classify enables, and a scratch byte. An enabled event sets a pending flag and pulls the open-drain interrupt line low. A host that sees the shared interrupt line go low reads the alert response address. Each device with a pending interrupt then sends its own address. A device that keeps control of the data line for the whole byte clears its flags and lets go of the line. A device that loses the line keeps its interrupt, so the host asks again.

Top module: `smb_alert_slave`

## Requirements
- R1: A byte whose upper seven bits equal {3'b010, addr_sel} is acknowledged for both write (LSB 0) and read (LSB 1). The acknowledge is the data line held low during the ninth clock.
- R2: Address 7'h30 is acknowledged for writes, and its writes reach the register file. A read from 7'h30 (byte 8'h61) is not acknowledged.
- R3: A read from 7'h0C (byte 8'h19) is acknowledged only while irq_oe is 1. While irq_oe is 0 it gets no acknowledge.
- R4: After an acknowledged alert read, the block sends {3'b010, addr_sel, 1'b0}. If it sends all eight bits without finding the line low while releasing it, every pending flag is cleared. If it finds the line low during a bit in which it released the line, it stops driving for the rest of the transfer and keeps its pending flags.
- R5: Write byte is START, address with write, command, data, STOP. The command byte loads the register pointer and the data byte is written at the pointer. The map is: 0x00 pending flags (writing 1 clears a bit), 0x01 event mask, 0x02 enables (bits [3:0] detect for ports 0..3, bits [7:4] classify for ports 0..3), 0x03 scratch. Other pointers read 8'h00 and ignore writes. All registers reset to zero.
- R6: Read byte is START, address with write, command, repeated START, address with read, then one data byte sent MSB first. The byte holds the register at the pointer. The host ends the read with NACK.
- R7: An event input sets its pending bit only when its mask bit is 1. irq_oe is 1 whenever any pending bit is 1.
- R8: When an enabled event is active in the same cycle as a write-1 clear of its pending bit, the bit stays set.
- R9: A pulse on shutdown_i[p] clears detect and classify enable p and outputs them as 0. The pulse takes priority over a register write in the same cycle. The bits stay cleared until the host writes them again.
- R10: A STOP or START inside a byte abandons the transfer, releases the data line and writes nothing. A START begins a new address phase.
- R11: Any other address is not acknowledged, and the block leaves the data line released for the rest of that transfer.
- R12: Both bus lines pass a two-flop synchronizer and then a three-sample filter. A pulse shorter than three clock cycles on SCL is not counted as a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_sel | input | 4 | Low four bits of the own address |
| evt_i | input | NEVT (8) | Event sources, active high |
| shutdown_i | input | NPORT (4) | Per-port shutdown pulses |
| irq_oe | output | 1 | 1 pulls the shared interrupt line low |
| det_en_o | output | NPORT (4) | Detect enables per port |
| cls_en_o | output | NPORT (4) | Classify enables per port |

## Verification
An event setting a pending bit and a bus write clearing it can fall in the same clock cycle. The bench provokes this by holding an enabled event high for the whole of a write-1 clear, so the clear cycle meets an active set. It then reads the flag back and expects it still set. After the event drops, a second clear must succeed. A shutdown pulse can also meet a write to the enable register; an assertion in the register file checks that shutdown takes priority in that case.

// File: rtl/smb_slave_pkg.sv
package smb_slave_pkg;

  localparam logic [2:0] PRIM_PREFIX = 3'b010;
  localparam logic [6:0] BCAST_ADDR  = 7'h30;
  localparam logic [6:0] ARA_ADDR    = 7'h0C;

  localparam logic [7:0] OFF_PEND    = 8'h00;
  localparam logic [7:0] OFF_MASK    = 8'h01;
  localparam logic [7:0] OFF_ENAB    = 8'h02;
  localparam logic [7:0] OFF_SCRATCH = 8'h03;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_DATA,
    ST_ACK,
    ST_TX,
    ST_HACK,
    ST_SKIP
  } bus_state_e;

  function automatic logic [6:0] primary_addr(input logic [3:0] sel);
    return {PRIM_PREFIX, sel};
  endfunction

  function automatic logic [7:0] ara_reply(input logic [3:0] sel);
    return {primary_addr(sel), 1'b0};
  endfunction

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TAPS        = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [TAPS-1:0]        hist_q;
  logic                   level_q;
  logic                   level_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      hist_q  <= '1;
      level_q <= 1'b1;
      level_d <= 1'b1;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], raw_i};
      hist_q  <= {hist_q[TAPS-2:0], sync_q[SYNC_STAGES-1]};
      if (&hist_q)
        level_q <= 1'b1;
      else if (~|hist_q)
        level_q <= 1'b0;
      level_d <= level_q;
    end
  end

  assign level_o = level_q;
  assign rise_o  = level_q & ~level_d;
  assign fall_o  = ~level_q & level_d;

  // the filtered level moves only after every tap agreed with the new value
  assert_filter_agree_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> ($past(hist_q) == {TAPS{level_q}}));

endmodule

// File: rtl/smb_reg_file.sv
module smb_reg_file
  import smb_slave_pkg::*;
#(
  parameter int unsigned NEVT    = 8,
  parameter int unsigned NPORT   = 4,
  parameter int unsigned CLS_LSB = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [7:0]       rd_addr,
  output logic [7:0]       rd_data,
  input  logic             ara_win,
  input  logic [NEVT-1:0]  evt_i,
  input  logic [NPORT-1:0] shutdown_i,
  output logic             irq_o,
  output logic [NPORT-1:0] det_en_o,
  output logic [NPORT-1:0] cls_en_o
);

  logic [NEVT-1:0] pend_q, pend_next, mask_q, evt_hit;
  logic [7:0]      scratch_q;
  logic            wr_pend, wr_mask, wr_enab, wr_scr;

  assign wr_pend = wr_en && (wr_addr == OFF_PEND);
  assign wr_mask = wr_en && (wr_addr == OFF_MASK);
  assign wr_enab = wr_en && (wr_addr == OFF_ENAB);
  assign wr_scr  = wr_en && (wr_addr == OFF_SCRATCH);
  assign evt_hit = evt_i & mask_q;

  // clear sources first, then set: an active enabled event always survives
  always_comb begin
    pend_next = pend_q;
    if (wr_pend) pend_next = pend_next & ~wr_data[NEVT-1:0];
    if (ara_win) pend_next = '0;
    pend_next = pend_next | evt_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      mask_q    <= '0;
      scratch_q <= '0;
    end else begin
      pend_q <= pend_next;
      if (wr_mask) mask_q    <= wr_data[NEVT-1:0];
      if (wr_scr)  scratch_q <= wr_data;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic det_q, cls_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        det_q <= 1'b0;
        cls_q <= 1'b0;
      end else if (shutdown_i[p]) begin
        det_q <= 1'b0;
        cls_q <= 1'b0;
      end else if (wr_enab) begin
        det_q <= wr_data[p];
        cls_q <= wr_data[CLS_LSB+p];
      end
    end
    assign det_en_o[p] = det_q;
    assign cls_en_o[p] = cls_q;

    assert_shutdown_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(shutdown_i[p]) |-> (!det_en_o[p] && !cls_en_o[p]));
  end

  always_comb begin
    rd_data = 8'h00;
    unique case (rd_addr)
      OFF_PEND:    rd_data[NEVT-1:0] = pend_q;
      OFF_MASK:    rd_data[NEVT-1:0] = mask_q;
      OFF_ENAB:    begin
                     rd_data[NPORT-1:0]         = det_en_o;
                     rd_data[CLS_LSB+:NPORT]    = cls_en_o;
                   end
      OFF_SCRATCH: rd_data = scratch_q;
      default:     rd_data = 8'h00;
    endcase
  end

  assign irq_o = |pend_q;

  assert_pend_needs_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q)) & ~$past(mask_q)) == '0);

  assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |=> ((pend_q & $past(evt_hit)) == $past(evt_hit)));

  assert_ara_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ara_win |=> ((pend_q & ~$past(evt_hit)) == '0));

endmodule

// File: rtl/smb_bus_engine.sv
module smb_bus_engine
  import smb_slave_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_lvl,
  input  logic       sda_rise,
  input  logic       sda_fall,
  input  logic [3:0] addr_sel,
  input  logic       irq_i,
  input  logic [7:0] rd_data,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic [7:0] rd_addr,
  output logic       ara_win,
  output logic       sda_oe
);

  bus_state_e state_q, next_q;
  logic [3:0] cnt_q;
  logic [7:0] rsh_q, tsh_q, ptr_q;
  logic       drive_q, ara_q, hack_q;

  logic       start_det, stop_det, byte_full, byte_end, addr_done;
  logic       rw, hit_prim, hit_bcast, hit_ara, ara_read, addr_ack;
  logic [7:0] reload;

  assign start_det = sda_fall & scl_lvl;
  assign stop_det  = sda_rise & scl_lvl;
  assign byte_full = (cnt_q == 4'd8);
  assign byte_end  = scl_fall & byte_full;
  assign addr_done = (state_q == ST_ADDR) && byte_end && !start_det && !stop_det;

  assign rw        = rsh_q[0];
  assign hit_prim  = (rsh_q[7:1] == primary_addr(addr_sel));
  assign hit_bcast = (rsh_q[7:1] == BCAST_ADDR);
  assign hit_ara   = (rsh_q[7:1] == ARA_ADDR);
  assign ara_read  = hit_ara & rw & irq_i;
  assign addr_ack  = hit_prim | (hit_bcast & ~rw) | ara_read;
  assign reload    = ara_q ? ara_reply(addr_sel) : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      next_q  <= ST_IDLE;
      cnt_q   <= '0;
      rsh_q   <= '0;
      tsh_q   <= '0;
      ptr_q   <= '0;
      drive_q <= 1'b0;
      ara_q   <= 1'b0;
      hack_q  <= 1'b0;
    end else if (start_det) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      drive_q <= 1'b0;
      ara_q   <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      drive_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_CMD, ST_DATA: begin
          if (scl_rise && !byte_full) begin
            rsh_q <= {rsh_q[6:0], sda_lvl};
            cnt_q <= cnt_q + 4'd1;
          end
          if (byte_end) begin
            cnt_q <= '0;
            if (state_q == ST_ADDR) begin
              if (addr_ack) begin
                drive_q <= 1'b1;
                state_q <= ST_ACK;
                next_q  <= rw ? ST_TX : ST_CMD;
                ara_q   <= ara_read;
                tsh_q   <= ara_read ? ara_reply(addr_sel) : rd_data;
              end else begin
                state_q <= ST_SKIP;
              end
            end else begin
              if (state_q == ST_CMD) ptr_q <= rsh_q;
              drive_q <= 1'b1;
              state_q <= ST_ACK;
              next_q  <= ST_DATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            state_q <= next_q;
            drive_q <= (next_q == ST_TX) ? ~tsh_q[7] : 1'b0;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            if (!drive_q && !sda_lvl) begin
              state_q <= ST_SKIP;
            end else begin
              cnt_q <= cnt_q + 4'd1;
              tsh_q <= {tsh_q[6:0], 1'b0};
            end
          end
          if (scl_fall) begin
            if (byte_full) begin
              drive_q <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_HACK;
            end else begin
              drive_q <= ~tsh_q[7];
            end
          end
        end
        ST_HACK: begin
          if (scl_rise) hack_q <= ~sda_lvl;
          if (scl_fall) begin
            if (hack_q) begin
              state_q <= ST_TX;
              tsh_q   <= reload;
              drive_q <= ~reload[7];
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign wr_en   = (state_q == ST_DATA) && byte_end && !start_det && !stop_det;
  assign wr_addr = ptr_q;
  assign wr_data = rsh_q;
  assign rd_addr = ptr_q;
  assign ara_win = (state_q == ST_TX) && byte_end && ara_q && !start_det && !stop_det;
  assign sda_oe  = drive_q;

  assert_own_addr_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && hit_prim) |=> (sda_oe && state_q == ST_ACK));

  assert_bcast_read_nack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && hit_bcast && rw) |=> (!sda_oe && state_q == ST_SKIP));

  assert_ara_needs_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && hit_ara && rw && !irq_i) |=> (state_q == ST_SKIP && !sda_oe));

  assert_foreign_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> !sda_oe);

  assert_release_on_cond_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !sda_oe);

  assert_sda_steady_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && $past(scl_lvl) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

endmodule

// File: rtl/smb_alert_slave.sv
module smb_alert_slave
  import smb_slave_pkg::*;
#(
  parameter int unsigned NEVT  = 8,
  parameter int unsigned NPORT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [3:0]       addr_sel,
  input  logic [NEVT-1:0]  evt_i,
  input  logic [NPORT-1:0] shutdown_i,
  output logic             irq_oe,
  output logic [NPORT-1:0] det_en_o,
  output logic [NPORT-1:0] cls_en_o
);

  localparam int unsigned CLS_LSB = 4;

  logic       scl_lvl, scl_rise, scl_fall;
  logic       sda_lvl, sda_rise, sda_fall;
  logic       wr_en, ara_win, irq;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

  smb_line_filter #(.SYNC_STAGES(2), .TAPS(3)) u_scl_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  smb_line_filter #(.SYNC_STAGES(2), .TAPS(3)) u_sda_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  smb_bus_engine u_engine (
    .clk(clk), .rst_n(rst_n),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .addr_sel(addr_sel), .irq_i(irq), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .ara_win(ara_win), .sda_oe(sda_oe)
  );

  smb_reg_file #(.NEVT(NEVT), .NPORT(NPORT), .CLS_LSB(CLS_LSB)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ara_win(ara_win),
    .evt_i(evt_i), .shutdown_i(shutdown_i), .irq_o(irq),
    .det_en_o(det_en_o), .cls_en_o(cls_en_o)
  );

  assign irq_oe = irq;

endmodule

// File: tb/smb_alert_slave_tb.sv
module smb_alert_slave_tb_top;

  localparam int Q = 20;
  localparam logic [3:0] SEL = 4'b0101;
  localparam logic [7:0] OWN_W = {3'b010, SEL, 1'b0};
  localparam logic [7:0] OWN_R = {3'b010, SEL, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_scl = 1'b1, host_sda = 1'b1, glitch = 1'b0, rival_low = 1'b0, glitch_on = 1'b0;
  logic [7:0] evt = '0;
  logic [3:0] sd = '0;
  logic sda_oe, irq_oe;
  logic [3:0] det_en, cls_en;
  wire scl_pin = host_scl ^ glitch;
  wire sda_bus = host_sda & ~sda_oe & ~rival_low;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  smb_alert_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_pin), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(SEL), .evt_i(evt), .shutdown_i(sd), .irq_oe(irq_oe),
    .det_en_o(det_en), .cls_en_o(cls_en)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    host_sda = 1'b1; wt(Q); host_scl = 1'b1; wt(Q);
    host_sda = 1'b0; wt(Q); host_scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; wt(Q); host_scl = 1'b1; wt(Q); host_sda = 1'b1; wt(Q);
  endtask

  task automatic send_bit(input logic b);
    host_sda = b;
    if (glitch_on) begin
      wt(Q / 2); glitch = 1'b1; wt(1); glitch = 1'b0; wt(Q / 2 - 1);
    end else wt(Q);
    host_scl = 1'b1;
    if (glitch_on) begin
      wt(Q); glitch = 1'b1; wt(1); glitch = 1'b0; wt(Q - 1);
    end else wt(2 * Q);
    host_scl = 1'b0; wt(Q);
  endtask

  task automatic recv_bit(input logic rival, output logic b);
    host_sda = 1'b1; rival_low = rival; wt(Q);
    host_scl = 1'b1; wt(Q); b = sda_bus; wt(Q);
    host_scl = 1'b0; wt(Q); rival_low = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(1'b0, b);
    ack = ~b;
  endtask

  task automatic recv_byte(input int rival_idx, output logic [7:0] v);
    logic b;
    for (int i = 0; i < 8; i++) begin
      recv_bit(i == rival_idx, b);
      v = {v[6:0], b};
    end
  endtask

  task automatic write_reg(input logic [7:0] abyte, input logic [7:0] cmd,
                           input logic [7:0] data, output logic ok);
    logic a0, a1, a2;
    bus_start(); send_byte(abyte, a0); send_byte(cmd, a1); send_byte(data, a2); bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic read_reg(input logic [7:0] cmd, output logic [7:0] data, output logic ok);
    logic a0, a1, a2;
    bus_start(); send_byte(OWN_W, a0); send_byte(cmd, a1);
    bus_start(); send_byte(OWN_R, a2); recv_byte(-1, data);
    send_bit(1'b1); bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic pulse_evt(input logic [7:0] v);
    evt = v; wt(1); evt = '0; wt(2);
  endtask

  task automatic t_reset();
    chk("R5 reset sda_oe", sda_oe, 1'b0);
    chk("R7 reset irq", irq_oe, 1'b0);
    chk("R5 reset enables", {cls_en, det_en}, 8'h00);
  endtask

  task automatic t_own_access();
    logic ok; logic [7:0] d;
    write_reg(OWN_W, 8'h03, 8'hA5, ok);
    chk("R1 own write ack", ok, 1'b1);
    read_reg(8'h03, d, ok);
    chk("R1 own read ack", ok, 1'b1);
    chk("R6 read scratch", d, 8'hA5);
    write_reg(OWN_W, 8'h03, 8'h5A, ok);
    read_reg(8'h03, d, ok);
    chk("R5 rewrite scratch", d, 8'h5A);
  endtask

  task automatic t_unmapped();
    logic ok; logic [7:0] d;
    write_reg(OWN_W, 8'h07, 8'hFF, ok);
    read_reg(8'h07, d, ok);
    chk("R5 unmapped reads zero", d, 8'h00);
    read_reg(8'h03, d, ok);
    chk("R5 unmapped write no effect", d, 8'h5A);
  endtask

  task automatic t_bcast();
    logic ok, a; logic [7:0] d;
    write_reg(8'h60, 8'h03, 8'h3C, ok);
    chk("R2 broadcast write ack", ok, 1'b1);
    read_reg(8'h03, d, ok);
    chk("R2 broadcast write lands", d, 8'h3C);
    bus_start(); send_byte(8'h61, a); bus_stop();
    chk("R2 broadcast read nack", a, 1'b0);
  endtask

  task automatic t_foreign();
    logic a; logic seen = 1'b0;
    bus_start(); send_byte(8'h4C, a);
    for (int i = 0; i < 8 * 4 * Q; i++) begin
      if (i % (4 * Q) == 0) host_sda = 1'b1;
      if (i % (4 * Q) == Q) host_scl = 1'b1;
      if (i % (4 * Q) == 3 * Q) host_scl = 1'b0;
      if (sda_oe) seen = 1'b1;
      wt(1);
    end
    bus_stop();
    chk("R11 foreign addr nack", a, 1'b0);
    chk("R11 foreign never drives", seen, 1'b0);
  endtask

  task automatic t_ara_no_irq();
    logic a;
    bus_start(); send_byte(8'h19, a); bus_stop();
    chk("R3 alert addr without irq nack", a, 1'b0);
  endtask

  task automatic t_mask();
    logic ok; logic [7:0] d;
    pulse_evt(8'h04);
    chk("R7 masked event no irq", irq_oe, 1'b0);
    read_reg(8'h00, d, ok);
    chk("R7 masked event no flag", d, 8'h00);
    write_reg(OWN_W, 8'h01, 8'h05, ok);
    pulse_evt(8'h04);
    chk("R7 enabled event irq", irq_oe, 1'b1);
    read_reg(8'h00, d, ok);
    chk("R7 pending flag", d, 8'h04);
  endtask

  task automatic t_ara_win();
    logic a; logic [7:0] d; logic ok;
    bus_start(); send_byte(8'h19, a); recv_byte(-1, d); send_bit(1'b1); bus_stop();
    chk("R3 alert addr with irq ack", a, 1'b1);
    chk("R4 alert reply byte", d, OWN_W);
    chk("R4 irq released", irq_oe, 1'b0);
    read_reg(8'h00, d, ok);
    chk("R4 pending cleared", d, 8'h00);
  endtask

  task automatic t_ara_lost();
    logic a, ok; logic [7:0] d;
    pulse_evt(8'h01);
    chk("R7 second event irq", irq_oe, 1'b1);
    bus_start(); send_byte(8'h19, a); recv_byte(1, d);
    chk("R4 lost arbitration line", d, 8'h3F);
    chk("R4 lost releases sda", sda_oe, 1'b0);
    send_bit(1'b1); bus_stop();
    chk("R4 lost keeps irq", irq_oe, 1'b1);
    write_reg(OWN_W, 8'h00, 8'h01, ok);
    chk("R5 write-1 clear drops irq", irq_oe, 1'b0);
  endtask

  task automatic t_collide();
    logic ok; logic [7:0] d;
    evt = 8'h01;
    write_reg(OWN_W, 8'h00, 8'h01, ok);
    wt(2);
    evt = 8'h00;
    read_reg(8'h00, d, ok);
    chk("R8 set wins over clear", d, 8'h01);
    write_reg(OWN_W, 8'h00, 8'h01, ok);
    read_reg(8'h00, d, ok);
    chk("R8 later clear works", d, 8'h00);
  endtask

  task automatic t_shutdown();
    logic ok; logic [7:0] d;
    write_reg(OWN_W, 8'h02, 8'hFF, ok);
    chk("R5 enables written", {cls_en, det_en}, 8'hFF);
    sd = 4'b0010; wt(1); sd = '0; wt(2);
    chk("R9 shutdown clears port1", {cls_en, det_en}, 8'hDD);
    wt(200);
    read_reg(8'h02, d, ok);
    chk("R9 stays cleared", d, 8'hDD);
    write_reg(OWN_W, 8'h02, 8'hFF, ok);
    chk("R9 host re-enables", {cls_en, det_en}, 8'hFF);
  endtask

  task automatic t_abort();
    logic a0, a1, a2, ok; logic [7:0] d;
    bus_start(); send_byte(OWN_W, a0); send_byte(8'h03, a1);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    bus_stop();
    chk("R10 stop releases sda", sda_oe, 1'b0);
    read_reg(8'h03, d, ok);
    chk("R10 stop mid byte no write", d, 8'h3C);
    bus_start(); send_byte(OWN_W, a0); send_byte(8'h03, a1);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start(); send_byte(OWN_R, a2); recv_byte(-1, d); send_bit(1'b1); bus_stop();
    chk("R10 restart mid byte ack", a2, 1'b1);
    chk("R10 restart mid byte no write", d, 8'h3C);
  endtask

  task automatic t_glitch();
    logic ok; logic [7:0] d;
    glitch_on = 1'b1;
    write_reg(OWN_W, 8'h03, 8'h96, ok);
    glitch_on = 1'b0;
    chk("R12 glitched write ack", ok, 1'b1);
    read_reg(8'h03, d, ok);
    chk("R12 glitched write value", d, 8'h96);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    wt(5); rst_n = 1'b1; wt(5);
    t_reset();
    t_own_access();
    t_unmapped();
    t_bcast();
    t_foreign();
    t_ara_no_irq();
    t_mask();
    t_ara_win();
    t_ara_lost();
    t_collide();
    t_shutdown();
    t_abort();
    t_glitch();
    done = 1'b1;
    report();
  end

  initial begin
    wt(190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end

endmodule